// File: doc/BRIEF.md
# Trap Vector Dispatch Unit

This block steers the program counter when the core takes a fault. Each cycle it looks at a bank of sixteen fault request lines. When any line is high, it picks one winner by fixed priority and looks up that fault's handler offset. It then forms the handler address from a programmable privileged base register and reports it, with the following sequential address, for one cycle under a valid strobe.

In the same cycle the block may save the interrupted PC into an exception-address register. Whether it does depends on the core's mode and on a per-request attribute bit. Trap-class faults then move the saved address past the faulting 4-byte instruction.

A saturating occurrence counter is kept for every fault kind. The base and exception-address registers can also be loaded through a small write port.

Top module: `trap_vector_dispatch`

## Requirements
- R1: After reset, disp_valid is 0, priv_base and exc_addr are 0 and every occurrence counter is 0.
- R2: Fault kinds are request bit indices with these handler offsets: 0 reset 0x0001, 1 machine check 0x0401, 2 interrupt 0x0101, 3 instruction access violation 0x0081, 4 instruction TLB miss 0x0181, 5 instruction page fault 0x0181, 6 double data TLB miss 0x0281, 7 single data TLB miss 0x0201, 8 unaligned 0x0301, 9 data page fault 0x0381, 10 data access violation 0x0381, 11 unimplemented opcode 0x0481, 12 float disabled 0x0581, 13 arithmetic 0x0501, 14 integer overflow 0x0501, 15 privileged call 0x2001.
- R3: When several request bits are high, the lowest bit index wins, so reset wins over everything, and disp_kind reports that index.
- R4: A cycle with any request makes disp_valid high in the next cycle only. In that cycle new_pc equals priv_base plus the winner's offset, and next_pc equals new_pc plus 4, both modulo 2^PC_W. A cycle with no request leaves disp_valid low in the next cycle.
- R5: On dispatch, exc_addr takes cur_pc when the winner's set-restart bit is 1 or priv_mode is 0. Otherwise it keeps its value.
- R6: For trap-class kinds 13, 14 and 15, exc_addr becomes the value left by R5 plus 4.
- R7: Kinds 4 and 5 produce the same new_pc, as do kinds 9 and 10, and kinds 13 and 14.
- R8: Each dispatch raises only the winner's counter by one. Counter k is event_counts[k*CNT_W +: CNT_W].
- R9: A counter at 2^CNT_W-1 stays there on further dispatches of its kind.
- R10: With wr_en high and no request, wr_sel=0 loads priv_base and wr_sel=1 loads exc_addr from wr_data in the next cycle. A write in a cycle with any request is ignored.
- R11: Only the winner's set-restart bit matters; set-restart bits of losing or idle requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_req | input | 16 | One request bit per fault kind |
| fault_setra | input | 16 | Per-kind set-restart attribute |
| priv_mode | input | 1 | Core is in privileged mode |
| cur_pc | input | PC_W | PC of the faulting instruction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects priv_base, 1 selects exc_addr |
| wr_data | input | PC_W | Register write data |
| disp_valid | output | 1 | Dispatch result valid |
| disp_kind | output | 4 | Index of the dispatched fault |
| new_pc | output | PC_W | Handler address |
| next_pc | output | PC_W | Address after the handler's first instruction |
| exc_addr | output | PC_W | Exception restart address register |
| priv_base | output | PC_W | Privileged base register |
| event_counts | output | 16*CNT_W | Packed occurrence counters |

## Verification
Every kind is dispatched alone under a nonzero base. This exposes a wrong offset or shared-vector entry, and a missing +4 on next_pc.

Requests are also raised together. All bits at once, a sparse set and a pair where only the loser has its set-restart bit show whether the arbiter picks the lowest index and takes the attribute from the winner.

The restart-address cases cross mode with the attribute bit and with trap class, which separates the save rule from the skip rule. Repeated dispatch of one kind drives its counter into saturation while the others must stay unchanged. Writes raised together with a request show that the register port is held off during dispatch.

// File: rtl/tvd_pkg.sv
package tvd_pkg;
  localparam int NUM_KINDS = 16;
  localparam int KIND_W    = $clog2(NUM_KINDS);
  localparam int VEC_W     = 14;
  localparam int INSN_BYTES = 4;

  typedef enum logic [KIND_W-1:0] {
    FK_RESET    = 4'd0,
    FK_MCHK     = 4'd1,
    FK_INTR     = 4'd2,
    FK_IACV     = 4'd3,
    FK_IMISS    = 4'd4,
    FK_IPAGE    = 4'd5,
    FK_DMISS2   = 4'd6,
    FK_DMISS1   = 4'd7,
    FK_UNALIGN  = 4'd8,
    FK_DPAGE    = 4'd9,
    FK_DACV     = 4'd10,
    FK_OPDEC    = 4'd11,
    FK_FPOFF    = 4'd12,
    FK_ARITH    = 4'd13,
    FK_OVF      = 4'd14,
    FK_PRIVCALL = 4'd15
  } fault_kind_e;

  // Handler offset for a fault kind.
  function automatic logic [VEC_W-1:0] vector_of(input logic [KIND_W-1:0] k);
    case (fault_kind_e'(k))
      FK_RESET:             vector_of = 14'h0001;
      FK_MCHK:              vector_of = 14'h0401;
      FK_INTR:              vector_of = 14'h0101;
      FK_IACV:              vector_of = 14'h0081;
      FK_IMISS, FK_IPAGE:   vector_of = 14'h0181;
      FK_DMISS2:            vector_of = 14'h0281;
      FK_DMISS1:            vector_of = 14'h0201;
      FK_UNALIGN:           vector_of = 14'h0301;
      FK_DPAGE, FK_DACV:    vector_of = 14'h0381;
      FK_OPDEC:             vector_of = 14'h0481;
      FK_FPOFF:             vector_of = 14'h0581;
      FK_ARITH, FK_OVF:     vector_of = 14'h0501;
      default:              vector_of = 14'h2001;
    endcase
  endfunction

  // Trap-class kinds resume after the faulting instruction.
  function automatic logic skips_insn(input logic [KIND_W-1:0] k);
    skips_insn = (k == FK_ARITH) || (k == FK_OVF) || (k == FK_PRIVCALL);
  endfunction

  function automatic logic [31:0] handler_addr(input logic [31:0] base,
                                               input logic [KIND_W-1:0] k);
    handler_addr = base + 32'(vector_of(k));
  endfunction
endpackage

// File: rtl/tvd_prio_arb.sv
module tvd_prio_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R3: at most one grant, and only to a requester
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  a_r3_grant_matches_idx: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/tvd_event_ctr.sv
module tvd_event_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (inc && !at_max) count <= count + 1'b1;
  end

  // R9: saturation holds
  a_r9_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |=> (count == CNT_MAX));
  // R8: one step per dispatch, no change otherwise
  a_r8_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_max) |=> (count == CNT_W'($past(count) + 1'b1)));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/trap_vector_dispatch.sv
module trap_vector_dispatch
  import tvd_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int CNT_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_KINDS-1:0]       fault_req,
  input  logic [NUM_KINDS-1:0]       fault_setra,
  input  logic                       priv_mode,
  input  logic [PC_W-1:0]            cur_pc,
  input  logic                       wr_en,
  input  logic                       wr_sel,
  input  logic [PC_W-1:0]            wr_data,
  output logic                       disp_valid,
  output logic [KIND_W-1:0]          disp_kind,
  output logic [PC_W-1:0]            new_pc,
  output logic [PC_W-1:0]            next_pc,
  output logic [PC_W-1:0]            exc_addr,
  output logic [PC_W-1:0]            priv_base,
  output logic [NUM_KINDS*CNT_W-1:0] event_counts
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  // Named internal events
  logic [NUM_KINDS-1:0] grant;
  logic [KIND_W-1:0]    win_idx;
  logic                 any_req;
  logic                 save_ra;
  logic                 skip_fault;
  logic [PC_W-1:0]      win_target;
  logic [PC_W-1:0]      restart_base;
  logic [PC_W-1:0]      restart_next;
  logic                 wr_base_go;
  logic                 wr_exc_go;

  tvd_prio_arb #(.N(NUM_KINDS), .IW(KIND_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (fault_req),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_req)
  );

  assign save_ra      = fault_setra[win_idx] | ~priv_mode;
  assign skip_fault   = skips_insn(win_idx);
  assign win_target   = priv_base + PC_W'(vector_of(win_idx));
  assign restart_base = save_ra ? cur_pc : exc_addr;
  assign restart_next = skip_fault ? restart_base + STEP : restart_base;
  assign wr_base_go   = wr_en & ~any_req & ~wr_sel;
  assign wr_exc_go    = wr_en & ~any_req &  wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_kind  <= '0;
      new_pc     <= '0;
      next_pc    <= '0;
    end else begin
      disp_valid <= any_req;
      if (any_req) begin
        disp_kind <= win_idx;
        new_pc    <= win_target;
        next_pc   <= win_target + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          exc_addr <= '0;
    else if (any_req)    exc_addr <= restart_next;
    else if (wr_exc_go)  exc_addr <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          priv_base <= '0;
    else if (wr_base_go) priv_base <= wr_data;
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_ctr
    tvd_event_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (grant[k]),
      .count (event_counts[k*CNT_W +: CNT_W])
    );
  end

  // R4: valid follows request cycles
  a_r4_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> disp_valid);
  a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !disp_valid);
  a_r4_target: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> (new_pc == $past(priv_base) + PC_W'(vector_of(disp_kind))));
  a_r4_next_seq: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (next_pc == new_pc + STEP));
  // R5: restart address saved or held
  a_r5_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && save_ra && !skip_fault) |=> (exc_addr == $past(cur_pc)));
  a_r5_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !save_ra && !skip_fault) |=> $stable(exc_addr));
  // R6: trap classes step past the instruction
  a_r6_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && save_ra && skip_fault) |=> (exc_addr == $past(cur_pc) + STEP));
  // R10: register port
  a_r10_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req && !(wr_en && wr_sel)) |=> $stable(exc_addr));
  a_r10_base_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> $stable(priv_base));
endmodule

// File: tb/trap_vector_dispatch_tb.sv
module trap_vector_dispatch_tb;
  localparam int NK = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NK-1:0] fault_req = '0;
  logic [NK-1:0] fault_setra = '0;
  logic          priv_mode = 1'b0;
  logic [31:0]   cur_pc = '0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          disp_valid;
  logic [3:0]    disp_kind;
  logic [31:0]   new_pc, next_pc, exc_addr, priv_base;
  logic [NK*CW-1:0] event_counts;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] base_m = '0;
  logic [31:0] exc_m = '0;
  int cnt_m [NK];

  always #2 clk = ~clk;

  trap_vector_dispatch #(.PC_W(32), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_setra(fault_setra),
    .priv_mode(priv_mode), .cur_pc(cur_pc), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .disp_valid(disp_valid), .disp_kind(disp_kind),
    .new_pc(new_pc), .next_pc(next_pc), .exc_addr(exc_addr),
    .priv_base(priv_base), .event_counts(event_counts)
  );

  function automatic logic [31:0] ref_off(input int k);
    case (k)
      0: return 32'h0001;   1: return 32'h0401;   2: return 32'h0101;
      3: return 32'h0081;   4: return 32'h0181;   5: return 32'h0181;
      6: return 32'h0281;   7: return 32'h0201;   8: return 32'h0301;
      9: return 32'h0381;  10: return 32'h0381;  11: return 32'h0481;
      12: return 32'h0581; 13: return 32'h0501;  14: return 32'h0501;
      default: return 32'h2001;
    endcase
  endfunction

  function automatic logic [CW-1:0] cnt_of(input int k);
    return event_counts[k*CW +: CW];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    for (int k = 0; k < NK; k++) chk(tag, 64'(cnt_of(k)), 64'(cnt_m[k]));
  endtask

  task automatic do_fault(input logic [NK-1:0] rq, input logic [NK-1:0] sa,
                          input logic pv, input logic [31:0] pc, input string tag);
    int w;
    logic [31:0] tgt;
    w = -1;
    for (int i = NK - 1; i >= 0; i--) if (rq[i]) w = i;
    tgt = base_m + ref_off(w);
    if (sa[w] || !pv) exc_m = pc;
    if (w >= 13) exc_m = exc_m + 32'd4;
    if (cnt_m[w] < (1 << CW) - 1) cnt_m[w]++;
    @(negedge clk);
    fault_req = rq; fault_setra = sa; priv_mode = pv; cur_pc = pc;
    @(posedge clk); #1;
    fault_req = '0; fault_setra = '0;
    chk({tag, " R4 valid"}, 64'(disp_valid), 64'd1);
    chk({tag, " R3 kind"}, 64'(disp_kind), 64'(w));
    chk({tag, " R2 R4 new_pc"}, 64'(new_pc), 64'(tgt));
    chk({tag, " R4 next_pc"}, 64'(next_pc), 64'(tgt + 32'd4));
    chk({tag, " R5 R6 exc_addr"}, 64'(exc_addr), 64'(exc_m));
    chk({tag, " R8 count"}, 64'(cnt_of(w)), 64'(cnt_m[w]));
    @(posedge clk); #1;
    chk({tag, " R4 valid drops"}, 64'(disp_valid), 64'd0);
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (sel) exc_m = d; else base_m = d;
    chk("R10 base write", 64'(priv_base), 64'(base_m));
    chk("R10 exc write", 64'(exc_addr), 64'(exc_m));
  endtask

  task automatic t_reset();
    chk("R1 valid", 64'(disp_valid), 64'd0);
    chk("R1 base", 64'(priv_base), 64'd0);
    chk("R1 exc", 64'(exc_addr), 64'd0);
    check_counts("R1 counts");
  endtask

  task automatic t_vectors();
    for (int k = 0; k < NK; k++)
      do_fault(NK'(1) << k, NK'(1) << k, 1'b1, 32'h0000_4000 + 32'(k * 16), "R2 single");
  endtask

  task automatic t_shared();
    logic [31:0] a;
    do_fault(NK'(1) << 4, '0, 1'b1, 32'h100, "R7 imiss"); a = new_pc;
    do_fault(NK'(1) << 5, '0, 1'b1, 32'h104, "R7 ipage"); chk("R7 itlb share", 64'(new_pc), 64'(a));
    do_fault(NK'(1) << 9, '0, 1'b1, 32'h108, "R7 dpage"); a = new_pc;
    do_fault(NK'(1) << 10, '0, 1'b1, 32'h10c, "R7 dacv"); chk("R7 data share", 64'(new_pc), 64'(a));
    do_fault(NK'(1) << 13, '0, 1'b1, 32'h110, "R7 arith"); a = new_pc;
    do_fault(NK'(1) << 14, '0, 1'b1, 32'h114, "R7 ovf"); chk("R7 arith share", 64'(new_pc), 64'(a));
  endtask

  task automatic t_priority();
    do_fault('1, '0, 1'b0, 32'h2000, "R3 all");
    do_fault(16'h8088, '0, 1'b0, 32'h2010, "R3 sparse");
    do_fault(16'h5000, '0, 1'b0, 32'h2020, "R3 pair");
    wr_reg(1'b1, 32'hABCD_0000);
    do_fault(16'h0088, 16'h0080, 1'b1, 32'h2030, "R11 loser attr");
    chk("R11 exc held", 64'(exc_addr), 64'h0000_0000_ABCD_0000);
  endtask

  task automatic t_mode();
    wr_reg(1'b1, 32'h1111_0000);
    do_fault(NK'(1) << 8, '0, 1'b1, 32'h3000, "R5 priv noattr");
    chk("R5 held", 64'(exc_addr), 64'h1111_0000);
    do_fault(NK'(1) << 8, NK'(1) << 8, 1'b1, 32'h3004, "R5 priv attr");
    chk("R5 saved priv", 64'(exc_addr), 64'h3004);
    do_fault(NK'(1) << 8, '0, 1'b0, 32'h3008, "R5 user");
    chk("R5 saved user", 64'(exc_addr), 64'h3008);
  endtask

  task automatic t_skip();
    do_fault(NK'(1) << 15, '0, 1'b0, 32'h5000, "R6 call user");
    chk("R6 call plus4", 64'(exc_addr), 64'h5004);
    wr_reg(1'b1, 32'h0000_7000);
    do_fault(NK'(1) << 14, '0, 1'b1, 32'h5100, "R6 ovf priv");
    chk("R6 held plus4", 64'(exc_addr), 64'h7004);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) do_fault(NK'(1) << 8, '0, 1'b1, 32'h6000, "R9 repeat");
    chk("R9 saturated", 64'(cnt_of(8)), 64'(2 ** CW - 1));
    check_counts("R8 R9 all counts");
  endtask

  task automatic t_wr_blocked();
    logic [31:0] b0;
    b0 = base_m;
    @(negedge clk);
    fault_req = NK'(1) << 2; fault_setra = '0; priv_mode = 1'b0; cur_pc = 32'h9000;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hDEAD_0000;
    @(posedge clk); #1;
    fault_req = '0; wr_en = 1'b0;
    if (cnt_m[2] < (1 << CW) - 1) cnt_m[2]++;
    exc_m = 32'h9000;
    chk("R10 base ignored", 64'(priv_base), 64'(b0));
    chk("R10 dispatch target", 64'(new_pc), 64'(b0 + 32'h0101));
    @(negedge clk);
    fault_req = NK'(1) << 2; cur_pc = 32'h9100;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'hDEAD_0004;
    @(posedge clk); #1;
    fault_req = '0; wr_en = 1'b0;
    if (cnt_m[2] < (1 << CW) - 1) cnt_m[2]++;
    exc_m = 32'h9100;
    chk("R10 exc write ignored", 64'(exc_addr), 64'h9100);
    @(posedge clk); #1;
    check_counts("R8 after blocked");
  endtask

  initial begin
    for (int k = 0; k < NK; k++) cnt_m[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    wr_reg(1'b0, 32'h0001_0000);
    t_vectors();
    t_shared();
    t_priority();
    t_mode();
    t_skip();
    wr_reg(1'b0, 32'hFFFF_F000);
    do_fault(NK'(1) << 15, NK'(1) << 15, 1'b1, 32'h7FFC, "R4 base wrap");
    t_sat();
    t_wr_blocked();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule